// File: doc/BRIEF.md
# Cartridge Program Bank Mapper

This block sits on the CPU write path of a game cartridge and turns register writes into physical bank numbers for the four 8 KB program windows. These windows cover CPU addresses 0x8000 to 0xFFFF, and the block also produces the nametable mirroring select. Software writes a register index to one port, then a value to a second port. Index 6 and index 7 load the two switchable banks, which appear in the windows at 0x8000 and 0xA000. Index 0 carries an outer bank bit. That bit is ORed at bit 6 into every window. An index-0 write also moves the two upper windows to the fixed pair 0x3E/0x3F, combined with the outer bit.

Address bit 11 plays no part in decoding, so each port appears twice. After reset the upper windows point at the last two banks of the ROM, set by a parameter. They stay there until the first index-0 write. A strap input marks boards with four-screen nametables, and on those boards mirroring writes are ignored. All outputs are registered.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the outputs are: window 4 = 0, window 5 = 1, window 6 = ROM_BANKS-2, window 7 = ROM_BANKS-1, and mirror_horiz = 0.
- R2: Address bit 11 is ignored when decoding. 0x8800, 0x8801 and 0xA800 act exactly like 0x8000, 0x8001 and 0xA000.
- R3: A write to 0x8000 stores the full 8-bit index. A write to 0x8001 acts on the register selected by the most recently stored index.
- R4: A data write with index 6 loads the first bank value, and window 4 becomes that value OR outer. A data write with index 7 loads the second bank value, and window 5 becomes that value OR outer.
- R5: A data write with index exactly 0x00 sets outer = data bit 1 moved to bit 6 (0x40 or 0x00). It sets window 6 = 0x3E OR outer and window 7 = 0x3F OR outer. It also recomputes windows 4 and 5 with the new outer value.
- R6: A data write with any other index (1 to 5, 8 to 255, including 0x80) changes no stored value and no window output.
- R7: When four_screen is low, a write to 0xA000 sets mirror_horiz to data bit 0 (1 = horizontal, 0 = vertical).
- R8: When four_screen is high, a write to 0xA000 leaves mirror_horiz unchanged.
- R9: Writes to any other address (for example 0xA001, 0xC000, 0xE001 or 0x7FFF) change no output.
- R10: Outputs change on the clock edge that samples the write strobe, and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| four_screen | input | 1 | Strap: board has four-screen nametables |
| bank_w4 | output | 8 | Bank for window 0x8000-0x9FFF |
| bank_w5 | output | 8 | Bank for window 0xA000-0xBFFF |
| bank_w6 | output | 8 | Bank for window 0xC000-0xDFFF |
| bank_w7 | output | 8 | Bank for window 0xE000-0xFFFF |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The subtle case is the interaction between the outer bit and the switchable windows. Setting the outer bit through index 0 must re-tag windows 4 and 5 that were loaded earlier. A later index-6 or index-7 write must carry the outer bit it finds at that moment. The directed stimulus therefore loads both banks first and then toggles the outer bit on and off. It then reloads the banks and confirms that a non-zero index such as 0x80 never acts as index 0. The aliased addresses and the four-screen strap are driven in the middle of that sequence. This catches decodes that stop matching once the state is no longer at its reset values.

// File: rtl/prg_mapper_pkg.sv
// Package: shared decode constants and the write-kind type for the
// program bank mapper. Assumes a 16-bit CPU address bus and 8-bit data.
package prg_mapper_pkg;

    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_INDEX  = 2'd1,
        WR_DATA   = 2'd2,
        WR_MIRROR = 2'd3
    } wr_kind_e;

    localparam int          ADDR_W      = 16;
    localparam logic [15:0] ALIAS_MASK  = 16'hF7FF;
    localparam logic [15:0] PORT_INDEX  = 16'h8000;
    localparam logic [15:0] PORT_DATA   = 16'h8001;
    localparam logic [15:0] PORT_MIRROR = 16'hA000;

    localparam logic [7:0]  IDX_OUTER   = 8'h00;
    localparam logic [7:0]  IDX_FIRST   = 8'h06;
    localparam logic [7:0]  IDX_SECOND  = 8'h07;

    localparam logic [7:0]  TOP_LO_BANK = 8'h3E;
    localparam logic [7:0]  TOP_HI_BANK = 8'h3F;

    localparam int          OUTER_SRC   = 1;
    localparam int          OUTER_DST   = 6;

endpackage

// File: rtl/mapper_wr_decode.sv
// Module: classifies a CPU write into one of the mapper's ports.
// Assumes wr_en is a single-cycle strobe; address bit 11 is ignored.
module mapper_wr_decode
    import prg_mapper_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_kind_e          kind
);

    logic [ADDR_W-1:0] masked;

    // Purpose: fold the alias bit away and match the three live ports.
    always_comb begin
        masked = wr_addr & ALIAS_MASK;
        kind   = WR_NONE;
        if (wr_en) begin
            unique case (masked)
                PORT_INDEX:  kind = WR_INDEX;
                PORT_DATA:   kind = WR_DATA;
                PORT_MIRROR: kind = WR_MIRROR;
                default:     kind = WR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mapper_bank_regs.sv
// Module: holds the index, the two switchable bank values and the outer
// bank bit. It presents their next-state values so the window stage can
// register results in the same cycle as the write. Assumes one write per cycle.
module mapper_bank_regs
    import prg_mapper_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BANK_W-1:0] nxt_first,
    output logic [BANK_W-1:0] nxt_second,
    output logic [BANK_W-1:0] nxt_outer,
    output logic              data_wr,
    output logic              outer_wr
);

    logic [DATA_W-1:0] index_q;
    logic [BANK_W-1:0] first_q;
    logic [BANK_W-1:0] second_q;
    logic [BANK_W-1:0] outer_q;

    // Purpose: decide which stored value the current data write targets.
    always_comb begin
        data_wr    = (kind == WR_DATA);
        outer_wr   = data_wr && (index_q == DATA_W'(IDX_OUTER));
        nxt_first  = first_q;
        nxt_second = second_q;
        nxt_outer  = outer_q;
        if (outer_wr) begin
            nxt_outer            = '0;
            nxt_outer[OUTER_DST] = wr_data[OUTER_SRC];
        end
        if (data_wr && index_q == DATA_W'(IDX_FIRST)) begin
            nxt_first = BANK_W'(wr_data);
        end
        if (data_wr && index_q == DATA_W'(IDX_SECOND)) begin
            nxt_second = BANK_W'(wr_data);
        end
    end

    // Purpose: latch the index on writes to the index port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (kind == WR_INDEX) begin
            index_q <= wr_data;
        end
    end

    // Purpose: commit bank values and the outer bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= BANK_W'(0);
            second_q <= BANK_W'(1);
            outer_q  <= '0;
        end else begin
            first_q  <= nxt_first;
            second_q <= nxt_second;
            outer_q  <= nxt_outer;
        end
    end

    // R3: the index only moves after an index-port write.
    a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(kind) != WR_INDEX) |-> $stable(index_q));

    // R6: the outer bit only moves after a data write with index 0.
    a_r6_outer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(outer_wr) |-> $stable(outer_q));

    // R5: the outer value never has a bit other than the destination bit.
    a_r5_outer_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(outer_q) <= 1 && (outer_q[OUTER_DST] || outer_q == '0));

endmodule

// File: rtl/mapper_window_out.sv
// Module: registered bank numbers for the four program windows.
// Assumes ROM_BANKS is even and at least 2, so the top pair is aligned.
module mapper_window_out
    import prg_mapper_pkg::*;
#(
    parameter int BANK_W    = 8,
    parameter int ROM_BANKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic              outer_wr,
    input  logic [BANK_W-1:0] nxt_first,
    input  logic [BANK_W-1:0] nxt_second,
    input  logic [BANK_W-1:0] nxt_outer,
    output logic [BANK_W-1:0] bank_w4,
    output logic [BANK_W-1:0] bank_w5,
    output logic [BANK_W-1:0] bank_w6,
    output logic [BANK_W-1:0] bank_w7
);

    localparam logic [BANK_W-1:0] RST_W6 = BANK_W'(ROM_BANKS - 2);
    localparam logic [BANK_W-1:0] RST_W7 = BANK_W'(ROM_BANKS - 1);

    // Purpose: the switchable windows follow every data-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_w4 <= BANK_W'(0);
            bank_w5 <= BANK_W'(1);
        end else if (data_wr) begin
            bank_w4 <= nxt_first | nxt_outer;
            bank_w5 <= nxt_second | nxt_outer;
        end
    end

    // Purpose: the upper windows jump to the fixed pair on an index-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_w6 <= RST_W6;
            bank_w7 <= RST_W7;
        end else if (outer_wr) begin
            bank_w6 <= BANK_W'(TOP_LO_BANK) | nxt_outer;
            bank_w7 <= BANK_W'(TOP_HI_BANK) | nxt_outer;
        end
    end

    // R10: switchable windows hold without a data write.
    a_r10_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(data_wr) |-> $stable(bank_w4) && $stable(bank_w5));

    // R5: the upper windows always form an even/odd pair.
    a_r5_top_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_w7 == (bank_w6 | BANK_W'(1))) && !bank_w6[0]);

    // R6: the upper windows move only on an index-0 data write.
    a_r6_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(outer_wr) |-> $stable(bank_w6));

endmodule

// File: rtl/mapper_mirror.sv
// Module: nametable mirroring select. Assumes the four-screen strap is
// static; while it is high the select is frozen.
module mapper_mirror
    import prg_mapper_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wr_kind_e kind,
    input  logic     data_bit0,
    input  logic     four_screen,
    output logic     mirror_horiz
);

    // Purpose: capture data bit 0 on a mirror-port write unless strapped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror_horiz <= 1'b0;
        end else if (kind == WR_MIRROR && !four_screen) begin
            mirror_horiz <= data_bit0;
        end
    end

    // R8: with the strap set, the select never moves.
    a_r8_strap_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(four_screen) |-> $stable(mirror_horiz));

    // R9: without a mirror-port write, the select never moves.
    a_r9_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(kind) != WR_MIRROR) |-> $stable(mirror_horiz));

endmodule

// File: rtl/prg_bank_mapper.sv
// Module: top of the program bank mapper. It decodes CPU writes and drives
// four registered 8 KB window bank numbers plus the mirroring select.
// Assumes a single clock domain and a one-cycle write strobe.
module prg_bank_mapper
    import prg_mapper_pkg::*;
#(
    parameter int BANK_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ROM_BANKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              four_screen,
    output logic [BANK_W-1:0] bank_w4,
    output logic [BANK_W-1:0] bank_w5,
    output logic [BANK_W-1:0] bank_w6,
    output logic [BANK_W-1:0] bank_w7,
    output logic              mirror_horiz
);

    wr_kind_e          kind;
    logic [BANK_W-1:0] nxt_first;
    logic [BANK_W-1:0] nxt_second;
    logic [BANK_W-1:0] nxt_outer;
    logic              data_wr;
    logic              outer_wr;

    mapper_wr_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .kind    (kind)
    );

    mapper_bank_regs #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .wr_data    (wr_data),
        .nxt_first  (nxt_first),
        .nxt_second (nxt_second),
        .nxt_outer  (nxt_outer),
        .data_wr    (data_wr),
        .outer_wr   (outer_wr)
    );

    mapper_window_out #(.BANK_W(BANK_W), .ROM_BANKS(ROM_BANKS)) u_windows (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .outer_wr   (outer_wr),
        .nxt_first  (nxt_first),
        .nxt_second (nxt_second),
        .nxt_outer  (nxt_outer),
        .bank_w4    (bank_w4),
        .bank_w5    (bank_w5),
        .bank_w6    (bank_w6),
        .bank_w7    (bank_w7)
    );

    mapper_mirror u_mirror (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .data_bit0    (wr_data[0]),
        .four_screen  (four_screen),
        .mirror_horiz (mirror_horiz)
    );

    // R2: an aliased data-port write is decoded like the base port.
    a_r2_alias_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ((wr_addr & 16'hF7FF) == 16'h8001) |-> data_wr);

endmodule

// File: tb/prg_bank_mapper_bench.sv
// Directed bench for prg_bank_mapper: one task per scenario.
module prg_bank_mapper_bench;

    localparam int ROM_BANKS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       four_screen = 1'b0;
    logic [7:0] bank_w4, bank_w5, bank_w6, bank_w7;
    logic       mirror_horiz;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prg_bank_mapper #(.ROM_BANKS(ROM_BANKS)) u_prg_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .four_screen(four_screen),
        .bank_w4(bank_w4), .bank_w5(bank_w5), .bank_w6(bank_w6),
        .bank_w7(bank_w7), .mirror_horiz(mirror_horiz)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [7:0] e4, input logic [7:0] e5,
                             input logic [7:0] e6, input logic [7:0] e7, input logic em);
        check({req, " w4"}, bank_w4, e4);
        check({req, " w5"}, bank_w5, e5);
        check({req, " w6"}, bank_w6, e6);
        check({req, " w7"}, bank_w7, e7);
        check({req, " mirror"}, {7'd0, mirror_horiz}, {7'd0, em});
    endtask

    // One write; returns at the falling edge after the sampling edge.
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check_all("R1 reset", 8'd0, 8'd1, 8'(ROM_BANKS - 2), 8'(ROM_BANKS - 1), 1'b0);
    endtask

    task automatic t_switch;
        bus_wr(16'h8000, 8'h06);
        check_all("R3 index only", 8'd0, 8'd1, 8'd30, 8'd31, 1'b0);
        bus_wr(16'h8001, 8'h05);
        check("R4 first", bank_w4, 8'h05);
        check("R10 update edge", bank_w5, 8'h01);
        @(negedge clk);
        check("R10 hold", bank_w4, 8'h05);
        bus_wr(16'h8000, 8'h07);
        bus_wr(16'h8001, 8'h1A);
        check_all("R4 second", 8'h05, 8'h1A, 8'd30, 8'd31, 1'b0);
    endtask

    task automatic t_outer;
        bus_wr(16'h8000, 8'h00);
        bus_wr(16'h8001, 8'h02);
        check_all("R5 outer set", 8'h45, 8'h5A, 8'h7E, 8'h7F, 1'b0);
        bus_wr(16'h8000, 8'h06);
        bus_wr(16'h8001, 8'h09);
        check("R5 outer on new bank", bank_w4, 8'h49);
        bus_wr(16'h8000, 8'h00);
        bus_wr(16'h8001, 8'hFD);
        check_all("R5 outer clear", 8'h09, 8'h1A, 8'h3E, 8'h3F, 1'b0);
    endtask

    task automatic t_alias;
        bus_wr(16'h8800, 8'h07);
        bus_wr(16'h8801, 8'h11);
        check("R2 alias data", bank_w5, 8'h11);
        bus_wr(16'hA800, 8'h01);
        check("R2 alias mirror", {7'd0, mirror_horiz}, 8'h01);
    endtask

    task automatic t_other_index;
        bus_wr(16'h8000, 8'h80);
        bus_wr(16'h8001, 8'h02);
        check_all("R6 index 0x80", 8'h09, 8'h11, 8'h3E, 8'h3F, 1'b1);
        bus_wr(16'h8000, 8'h03);
        bus_wr(16'h8001, 8'h22);
        check_all("R6 index 3", 8'h09, 8'h11, 8'h3E, 8'h3F, 1'b1);
    endtask

    task automatic t_mirror;
        bus_wr(16'hA000, 8'hFE);
        check("R7 vertical", {7'd0, mirror_horiz}, 8'h00);
        bus_wr(16'hA000, 8'h01);
        check("R7 horizontal", {7'd0, mirror_horiz}, 8'h01);
        four_screen = 1'b1;
        bus_wr(16'hA000, 8'h00);
        check("R8 strap ignores", {7'd0, mirror_horiz}, 8'h01);
        four_screen = 1'b0;
    endtask

    task automatic t_dead_ports;
        bus_wr(16'h8000, 8'h06);
        bus_wr(16'hA001, 8'h00);
        bus_wr(16'hC000, 8'h33);
        bus_wr(16'hE001, 8'h44);
        bus_wr(16'h7FFF, 8'h55);
        bus_wr(16'h8002, 8'h66);
        check_all("R9 other addresses", 8'h09, 8'h11, 8'h3E, 8'h3F, 1'b1);
        bus_wr(16'h8001, 8'h0C);
        check("R9 index survived", bank_w4, 8'h0C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_switch();
        t_outer();
        t_alias();
        t_other_index();
        t_mirror();
        t_dead_ports();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule